// File: doc/BRIEF.md
# Flash Read-Path Mode Multiplexer

This block is the output side of a parallel NOR flash model with a bus that can run eight or sixteen bits wide. It keeps track of which of three sources a read returns: the memory array, the status byte or the identification bytes. It then drives a 16-bit data bus and a per-bit output enable from the active-low chip-enable, output-enable and write-enable strobes and the active-low width select. A command decoder outside the block sends single-cycle mode events. The program and erase engine reports completion, busy and suspend. A high-voltage detector raises a level flag that forces identification reads while it is present.

The strobes are sampled on the block clock. Array words come from an external synchronous read port that returns the word for `arr_addr` one clock after the address is presented. The status byte is captured when the second of the two read strobes falls. It is shown at once in that cycle and then held until one of the strobes is toggled.

Top module: `flash_read_mux`

## Requirements
- R1: After reset the stored read mode is array, so the first read after reset returns array data.
- R2: A completion pulse (`op_done`) sets the stored mode to status. While `busy` is high, every read returns the status byte, and the stored mode comes back into effect when `busy` drops.
- R3: A `suspend_ev` pulse makes reads return status. This lasts until any of `cmd_array`, `cmd_status` or `cmd_id` is accepted, and such a command clears it. If a suspend pulse and a command arrive in the same cycle, the suspend wins.
- R4: A read is active only when `we_n` is 1 and both `oe_n` and `ce_n` are 0. In every other case `dq_oe` is 16'h0000 and `dq_out` is 16'h0000.
- R5: `status_in` is captured in the cycle where `oe_n` and `ce_n` become both low after not being both low, and it is shown in that same cycle. While both stay low the shown status does not change. Raising and lowering either strobe captures a fresh value.
- R6: Status and identification bytes always appear on `dq_out[7:0]`. With `byte_n`=1 the upper byte of a status read is 8'h00 and driven. With `byte_n`=0, `dq_oe[15:8]` is 0 for every source.
- R7: In identification mode `addr[0]`=0 gives `MFR_ID` and `addr[0]`=1 gives `DEV_ID` on the low byte. All other address bits have no effect.
- R8: For an identification read with `byte_n`=1, the upper byte is 8'h00 for the manufacturer byte and `DEV_ID_HI` (default 8'h22) for the device byte.
- R9: For an array read with `byte_n`=1, `dq_out` is the full 16-bit word returned by the read port, and `dq_oe` is 16'hFFFF.
- R10: For an array read with `byte_n`=0, `a_lsb`=0 selects word bits [7:0] and `a_lsb`=1 selects bits [15:8] onto `dq_out[7:0]`, and `dq_oe` is 16'h00FF.
- R11: While `id_force` is high, reads return identification bytes whatever the stored mode is. When it drops, the mode in effect before it rose comes back.
- R12: When several events come in the same cycle, the stored mode is chosen in this order: completion first, then status command, then identification command, then array command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| byte_n | input | 1 | Width select: 1 for 16-bit, 0 for 8-bit |
| addr | input | ADDR_W | Word address |
| a_lsb | input | 1 | Byte select in 8-bit mode (the top data pin used as an input) |
| id_force | input | 1 | High-voltage identification override |
| status_in | input | 8 | Live status byte from the program/erase engine |
| op_done | input | 1 | Program or erase finished (pulse) |
| busy | input | 1 | Program or erase in progress |
| suspend_ev | input | 1 | Erase suspended (pulse) |
| cmd_array | input | 1 | Decoder event: array read |
| cmd_status | input | 1 | Decoder event: status read |
| cmd_id | input | 1 | Decoder event: identification read |
| arr_addr | output | ADDR_W | Address to the synchronous array port |
| arr_rdata | input | 16 | Array word, one cycle after `arr_addr` |
| dq_out | output | 16 | Data bus value |
| dq_oe | output | 16 | Per-bit output enable |

## Verification
Two functions can land in one cycle: a status capture caused by a falling strobe, and a mode change caused by a completion or command pulse. The bench makes both happen at once by lowering the second strobe in the same cycle as `op_done`, and also by pulsing a suspend together with a command. A behavioural reference model in the bench predicts the bus for every cycle. That model must show the array word in the pulse cycle and the status byte captured in that cycle from the next cycle on, with no recapture.

// File: rtl/flash_read_mux.sv
module flash_read_mux #(
  parameter int ADDR_W = 17,
  parameter logic [7:0] MFR_ID = 8'h89,
  parameter logic [7:0] DEV_ID = 8'h74,
  parameter logic [7:0] DEV_ID_HI = 8'h22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              byte_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              a_lsb,
  input  logic              id_force,
  input  logic [7:0]        status_in,
  input  logic              op_done,
  input  logic              busy,
  input  logic              suspend_ev,
  input  logic              cmd_array,
  input  logic              cmd_status,
  input  logic              cmd_id,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [15:0]       arr_rdata,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_oe
);
  localparam logic [1:0] M_ARR  = 2'd0;
  localparam logic [1:0] M_STAT = 2'd1;
  localparam logic [1:0] M_ID   = 2'd2;

  logic [1:0] mode_q, eff_mode;
  logic       susp_q, both_q;
  logic [7:0] stat_q, stat_now;
  logic [7:0] lo, hi;

  wire both_low = ~oe_n & ~ce_n;
  wire rd       = we_n & both_low;
  wire cap      = both_low & ~both_q;
  wire cmd_any  = cmd_array | cmd_status | cmd_id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_ARR;
      susp_q <= 1'b0;
      both_q <= 1'b0;
      stat_q <= 8'h00;
    end else begin
      both_q <= both_low;
      if (cap) stat_q <= status_in;
      if (op_done)         mode_q <= M_STAT;
      else if (cmd_status) mode_q <= M_STAT;
      else if (cmd_id)     mode_q <= M_ID;
      else if (cmd_array)  mode_q <= M_ARR;
      if (suspend_ev)   susp_q <= 1'b1;
      else if (cmd_any) susp_q <= 1'b0;
    end
  end

  assign eff_mode = id_force       ? M_ID   :
                    (busy | susp_q) ? M_STAT : mode_q;
  assign stat_now = cap ? status_in : stat_q;
  assign arr_addr = addr;

  always_comb begin
    lo = stat_now;
    hi = 8'h00;
    case (eff_mode)
      M_ID: begin
        lo = addr[0] ? DEV_ID : MFR_ID;
        hi = addr[0] ? DEV_ID_HI : 8'h00;
      end
      M_STAT: ;
      default: begin
        if (byte_n) {hi, lo} = arr_rdata;
        else        lo = a_lsb ? arr_rdata[15:8] : arr_rdata[7:0];
      end
    endcase
  end

  assign dq_oe  = !rd ? 16'h0000 : (byte_n ? 16'hFFFF : 16'h00FF);
  assign dq_out = {hi, lo} & dq_oe;
endmodule

module flash_read_mux_chk #(
  parameter logic [7:0] DEV_ID = 8'h74,
  parameter logic [7:0] DEV_ID_HI = 8'h22
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_n,
  input logic        oe_n,
  input logic        we_n,
  input logic        byte_n,
  input logic        addr0,
  input logic        id_force,
  input logic        op_done,
  input logic        suspend_ev,
  input logic [15:0] dq_out,
  input logic [15:0] dq_oe,
  input logic [1:0]  mode_q,
  input logic        susp_q,
  input logic [1:0]  eff_mode
);
  wire rd = we_n & ~oe_n & ~ce_n;

  p_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (dq_oe == 16'h0000 && dq_out == 16'h0000));

  p_byte_upper_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !byte_n) |-> (dq_oe[15:8] == 8'h00));

  p_done_to_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> (mode_q == 2'd1));

  p_suspend_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_ev |=> susp_q);

  p_dev_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && byte_n && id_force && addr0) |-> (dq_out == {DEV_ID_HI, DEV_ID}));

  p_status_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && $past(rd) && $past(rst_n) && eff_mode == 2'd1 && $past(eff_mode) == 2'd1)
      |-> $stable(dq_out[7:0]));

  p_mode_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'd3);
endmodule

bind flash_read_mux flash_read_mux_chk #(.DEV_ID(DEV_ID), .DEV_ID_HI(DEV_ID_HI)) i_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .byte_n(byte_n),
  .addr0(addr[0]), .id_force(id_force), .op_done(op_done), .suspend_ev(suspend_ev),
  .dq_out(dq_out), .dq_oe(dq_oe), .mode_q(mode_q), .susp_q(susp_q), .eff_mode(eff_mode)
);

// File: tb/test_flash_read_mux.sv
`timescale 1ns/1ps
module test_flash_read_mux;
  localparam int AW = 17;
  localparam logic [7:0] MFR = 8'h89, DEV = 8'h74, DEVH = 8'h22;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, byte_n = 1, a_lsb = 0, id_force = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] status_in = 8'h00;
  logic op_done = 0, busy = 0, suspend_ev = 0, cmd_array = 0, cmd_status = 0, cmd_id = 0;
  logic [AW-1:0] arr_addr;
  logic [15:0] arr_rdata = 16'h0000;
  logic [15:0] dq_out, dq_oe;

  int checks = 0, fails = 0, cyc = 0;
  string cur_tag = "R4";
  bit done = 0;

  always #10 clk = ~clk;

  flash_read_mux #(.ADDR_W(AW), .MFR_ID(MFR), .DEV_ID(DEV), .DEV_ID_HI(DEVH)) i_flash_read_mux (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .byte_n(byte_n),
    .addr(addr), .a_lsb(a_lsb), .id_force(id_force), .status_in(status_in),
    .op_done(op_done), .busy(busy), .suspend_ev(suspend_ev), .cmd_array(cmd_array),
    .cmd_status(cmd_status), .cmd_id(cmd_id), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
    .dq_out(dq_out), .dq_oe(dq_oe));

  function automatic logic [15:0] memf(input logic [AW-1:0] a);
    logic [31:0] p;
    p = {15'd0, a} * 32'h9E37;
    return p[15:0] ^ 16'h5A3C;
  endfunction

  always @(posedge clk) arr_rdata <= memf(arr_addr);

  // behavioural reference: 0 array, 1 status, 2 id
  int m_mode, m_susp, m_prev_both;
  logic [7:0] m_stat;
  logic [AW-1:0] m_prev_addr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_susp = 0; m_prev_both = 0; m_stat = 8'h00;
    end else begin
      if (!oe_n && !ce_n && m_prev_both == 0) m_stat = status_in;
      m_prev_both = (!oe_n && !ce_n) ? 1 : 0;
      if (op_done) m_mode = 1;
      else if (cmd_status) m_mode = 1;
      else if (cmd_id) m_mode = 2;
      else if (cmd_array) m_mode = 0;
      if (suspend_ev) m_susp = 1;
      else if (cmd_array || cmd_status || cmd_id) m_susp = 0;
    end
    m_prev_addr = addr;
  end

  task automatic expect_bus(output logic [15:0] d, output logic [15:0] e);
    logic [7:0] lo, hi, st;
    logic [15:0] w;
    int eff;
    st = (!oe_n && !ce_n && m_prev_both == 0) ? status_in : m_stat;
    eff = id_force ? 2 : (busy || m_susp != 0) ? 1 : m_mode;
    w = memf(m_prev_addr);
    hi = 8'h00;
    if (eff == 2) begin
      lo = addr[0] ? DEV : MFR;
      hi = addr[0] ? DEVH : 8'h00;
    end else if (eff == 1) lo = st;
    else if (byte_n) begin lo = w[7:0]; hi = w[15:8]; end
    else lo = a_lsb ? w[15:8] : w[7:0];
    if (!(we_n && !oe_n && !ce_n)) e = 16'h0000;
    else if (byte_n) e = 16'hFFFF;
    else e = 16'h00FF;
    d = {hi, lo} & e;
  endtask

  always @(negedge clk) begin
    logic [15:0] ed, ee;
    if (rst_n && !done) begin
      expect_bus(ed, ee);
      checks++;
      if (dq_out !== ed || dq_oe !== ee) begin
        fails++;
        $display("FAIL %s model: dq_out=%h dq_oe=%h expected %h %h", cur_tag, dq_out, dq_oe, ed, ee);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic look();
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) step();
    rst_n = 1;
    cur_tag = "R4";
    step(); look(); chk("R4 idle oe", dq_oe, 16'h0000);

    cur_tag = "R1";
    addr = 17'd5; oe_n = 0; ce_n = 0;
    step(); look(); chk("R1 first read array", dq_out, memf(17'd5));

    cur_tag = "R9";
    for (int i = 0; i < 6; i++) begin addr = AW'(i * 371 + 3); step(); end
    look(); chk("R9 word oe", dq_oe, 16'hFFFF);

    cur_tag = "R10";
    byte_n = 0; addr = 17'd9; a_lsb = 1;
    step(); look();
    chk("R10 high byte", dq_out, {8'h00, memf(17'd9) >> 8});
    chk("R10 oe", dq_oe, 16'h00FF);
    a_lsb = 0; step(); look(); chk("R10 low byte", dq_out, {8'h00, memf(17'd9) & 16'h00FF});

    cur_tag = "R4";
    byte_n = 1; we_n = 0; step(); look(); chk("R4 we low", dq_oe, 16'h0000);
    we_n = 1; ce_n = 1; step(); look(); chk("R4 ce high", dq_out, 16'h0000);

    cur_tag = "R2";
    op_done = 1; step(); op_done = 0; status_in = 8'h80;
    oe_n = 0; ce_n = 0; step(); look(); chk("R2 status after done", dq_out, 16'h0080);
    cur_tag = "R5";
    status_in = 8'h81; step(); look(); chk("R5 held", dq_out, 16'h0080);
    oe_n = 1; step(); oe_n = 0; step(); look(); chk("R5 oe toggle", dq_out, 16'h0081);
    status_in = 8'h82; ce_n = 1; step(); ce_n = 0; step(); look(); chk("R5 ce toggle", dq_out, 16'h0082);

    cur_tag = "R2";
    cmd_array = 1; step(); cmd_array = 0; busy = 1; step(); look();
    chk("R2 busy status", dq_out, 16'h0082);
    busy = 0; addr = 17'd77; step(); look(); chk("R2 busy drop", dq_out, memf(17'd77));

    cur_tag = "R3";
    suspend_ev = 1; step(); suspend_ev = 0; step(); look(); chk("R3 suspended", dq_out, 16'h0082);
    cmd_array = 1; step(); cmd_array = 0; look(); chk("R3 cleared", dq_out, memf(17'd77));
    suspend_ev = 1; cmd_array = 1; step(); suspend_ev = 0; cmd_array = 0; step(); look();
    chk("R3 suspend wins", dq_out, 16'h0082);

    cur_tag = "R7";
    cmd_id = 1; step(); cmd_id = 0; addr = 17'h1AAA0; step(); look();
    chk("R7 mfr", dq_out, {8'h00, MFR});
    cur_tag = "R8";
    addr = 17'h05551; step(); look(); chk("R8 dev word", dq_out, {DEVH, DEV});
    cur_tag = "R7";
    addr = 17'h1FFFF; step(); look(); chk("R7 other bits ignored", dq_out, {DEVH, DEV});
    cur_tag = "R6";
    byte_n = 0; step(); look(); chk("R6 id byte mode", dq_out, {8'h00, DEV});
    chk("R6 id byte oe", dq_oe, 16'h00FF);
    cmd_status = 1; step(); cmd_status = 0; step(); look(); chk("R6 status byte oe", dq_oe, 16'h00FF);
    byte_n = 1; step(); look(); chk("R6 status word upper", dq_out, 16'h0082);

    cur_tag = "R11";
    cmd_array = 1; step(); cmd_array = 0; addr = 17'd1201; id_force = 1; step(); look();
    chk("R11 force id", dq_out, {DEVH, DEV});
    id_force = 0; step(); look(); chk("R11 restore array", dq_out, memf(17'd1201));
    cmd_status = 1; step(); cmd_status = 0; id_force = 1; addr = 17'd2; step(); look();
    chk("R11 force over status", dq_out, {8'h00, MFR});
    id_force = 0; step(); look(); chk("R11 restore status", dq_out, 16'h0082);

    cur_tag = "R12";
    op_done = 1; cmd_id = 1; step(); op_done = 0; cmd_id = 0; step(); look();
    chk("R12 done beats id", dq_out, 16'h0082);
    cmd_id = 1; cmd_array = 1; step(); cmd_id = 0; cmd_array = 0; addr = 17'd3; step(); look();
    chk("R12 id beats array", dq_out, {DEVH, DEV});
    cmd_status = 1; cmd_id = 1; step(); cmd_status = 0; cmd_id = 0; step(); look();
    chk("R12 status beats id", dq_out, 16'h0082);

    cur_tag = "R5";
    cmd_array = 1; step(); cmd_array = 0; oe_n = 1; step();
    status_in = 8'h9C; op_done = 1; oe_n = 0; addr = 17'd40; step(); op_done = 0; look();
    chk("R5 capture with done", dq_out, 16'h009C);
    status_in = 8'h11; step(); look(); chk("R5 no recapture", dq_out, 16'h009C);

    repeat (3) step();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule